// File: doc/BRIEF.md
# Cycle counter continuity monitor

This block watches a sequence counter that comes with every process-data update. It checks each new value against the value before it. A value is correct only if it is exactly one greater, and the step from the all-ones value to zero counts as correct. A lost update shows up as a jump. A repeated update shows up as an unchanged value. Either case is a continuity error.

Each error produces a one-cycle pulse and adds one to a saturating error count that software can read and clear. Each error also sets a fault flag. The output fallback logic uses this flag to select its substitute output. The flag stays set until a correct increment arrives.

The first value after reset, and the first value after monitoring is enabled, only sets the reference value and is never checked. The counter width and the error count width are parameters, with 8 bits as the default for both. Every output is a register, so each output reflects a sample one cycle after the clock edge that captures it.

Top module: `cycle_cnt_monitor`

## Requirements
- R1: After reset, err_o and fault_o are 0 and err_cnt_o is 0.
- R2: While monitoring is enabled and a reference value exists, a sampled value equal to the reference plus one raises no error. err_o is 0 in the following cycle.
- R3: The step from 255 to 0 is a correct increment and raises no error.
- R4: A sampled value that differs from the reference plus one sets err_o to 1 for exactly the cycle after the sampling edge. In that same cycle err_cnt_o rises by one.
- R5: A repeated value (equal to the reference) is a continuity error.
- R6: Every sampled value becomes the new reference. A single jump followed by correct increments therefore adds exactly one error.
- R7: The first value sampled after reset, or after en_i rises, only sets the reference and never raises an error.
- R8: While en_i is 0, samples are ignored and no error is raised. The reference is dropped and fault_o is 0 from the next cycle onward.
- R9: err_cnt_o saturates at 255. Further errors leave it at 255.
- R10: When clr_i is 1, err_cnt_o is 0 in the next cycle. If an error is detected on that same edge, err_cnt_o becomes 1 instead.
- R11: fault_o becomes 1 together with err_o. It stays 1 through idle cycles and later errors, and it returns to 0 in the cycle after a correct increment is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Monitoring enable |
| valid_i | input | 1 | Strobe marking a new process-data update |
| cnt_i | input | CNT_W | Sequence counter carried by the update |
| clr_i | input | 1 | Host strobe that clears the error count |
| err_o | output | 1 | One-cycle continuity error pulse |
| fault_o | output | 1 | Fault flag for the output fallback logic |
| err_cnt_o | output | ERR_W | Saturating continuity error count |

## Verification
A corrupted reference value shows up on the very next update. It produces either a spurious err_o pulse or a missed one, and err_cnt_o then moves by one in the wrong direction. A reference-valid bit that is stuck set shows up as an error on the first sample after reset or after enable. A stuck fault flag shows up when fault_o fails to drop one cycle after a correct increment. A wrong saturation or clear priority shows up only at 255 errors, or at a clear that coincides with an error.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  typedef enum logic {
    ST_NO_REF = 1'b0,
    ST_TRACK  = 1'b1
  } ref_state_e;
endpackage

// File: rtl/ccm_seq_check.sv
module ccm_seq_check
  import ccm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             mismatch_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] STEP = {{(CNT_W-1){1'b0}}, 1'b1};

  ref_state_e       state_q;
  logic [CNT_W-1:0] ref_q;
  logic [CNT_W-1:0] expect_val;
  logic             checked;

  assign expect_val = ref_q + STEP;
  assign checked    = en_i && valid_i && (state_q == ST_TRACK);
  assign mismatch_o = checked && (cnt_i != expect_val);
  assign match_o    = checked && (cnt_i == expect_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NO_REF;
      ref_q   <= '0;
    end else if (!en_i) begin
      state_q <= ST_NO_REF;
    end else if (valid_i) begin
      state_q <= ST_TRACK;
      ref_q   <= cnt_i;
    end
  end

  // R6: every sample while enabled becomes the new reference
  p_ref_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i) |=> (ref_q == $past(cnt_i)));
  // R8: disabling drops the reference
  p_disable_drops_ref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_NO_REF));
endmodule

// File: rtl/ccm_err_counter.sv
module ccm_err_counter #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [ERR_W-1:0] count_o
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;
  localparam logic [ERR_W-1:0] CNT_ONE = {{(ERR_W-1){1'b0}}, 1'b1};

  logic [ERR_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          count_q <= '0;
    else if (clr_i)                       count_q <= inc_i ? CNT_ONE : '0;
    else if (inc_i && count_q != CNT_MAX) count_q <= count_q + CNT_ONE;
  end

  assign count_o = count_q;

  // R9: saturation holds
  p_saturate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_MAX && !clr_i) |=> (count_q == CNT_MAX));
  // R10: clear leaves at most the coincident error
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_q <= CNT_ONE));
  // R4: an increment without clear never decreases the count
  p_monotonic_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (count_q >= $past(count_q)));
endmodule

// File: rtl/ccm_fault_flag.sv
module ccm_fault_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic ok_i,
  output logic fault_o
);
  logic fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fault_q <= 1'b0;
    else if (!en_i)  fault_q <= 1'b0;
    else if (set_i)  fault_q <= 1'b1;
    else if (ok_i)   fault_q <= 1'b0;
  end

  assign fault_o = fault_q;

  // R8: no fault while disabled
  p_off_when_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fault_q);
  // R11: sticky until a correct increment
  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && en_i && !ok_i) |=> fault_q);
endmodule

// File: rtl/cycle_cnt_monitor.sv
module cycle_cnt_monitor #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic             err_o,
  output logic             fault_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  logic mismatch;
  logic match;
  logic err_q;

  ccm_seq_check #(.CNT_W(CNT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .valid_i    (valid_i),
    .cnt_i      (cnt_i),
    .mismatch_o (mismatch),
    .match_o    (match)
  );

  ccm_err_counter #(.ERR_W(ERR_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (mismatch),
    .clr_i   (clr_i),
    .count_o (err_cnt_o)
  );

  ccm_fault_flag u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .set_i   (mismatch),
    .ok_i    (match),
    .fault_o (fault_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= mismatch;
  end

  assign err_o = err_q;

  // R8: disabled samples never raise an error
  p_no_err_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !err_o);
  // R4: a pulse only follows an enabled sample
  p_err_needs_sample_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && valid_i) |=> !err_o);
  // R11: fault flag accompanies every error pulse
  p_fault_with_err_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> fault_o);
endmodule

// File: tb/cycle_cnt_monitor_test.sv
module cycle_cnt_monitor_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] cnt_i = '0;
  logic       clr_i = 1'b0;
  logic       err_o;
  logic       fault_o;
  logic [7:0] err_cnt_o;

  always #2 clk_i = ~clk_i;

  cycle_cnt_monitor uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .valid_i(valid_i),
    .cnt_i(cnt_i), .clr_i(clr_i), .err_o(err_o), .fault_o(fault_o),
    .err_cnt_o(err_cnt_o)
  );

  typedef struct {
    logic       err;
    logic       fault;
    logic [7:0] cnt;
    string      req;
  } exp_t;

  exp_t queue_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // reference model state
  bit       m_ref_ok = 1'b0;
  bit [7:0] m_ref = '0;
  bit       m_fault = 1'b0;
  bit [7:0] m_cnt = '0;

  task automatic step(input bit en, input bit v, input bit [7:0] c,
                      input bit clr, input string req);
    exp_t e;
    bit   er;
    @(negedge clk_i);
    en_i = en; valid_i = v; cnt_i = c; clr_i = clr;
    er = en && v && m_ref_ok && (c != 8'(m_ref + 8'd1));
    if (clr) m_cnt = er ? 8'd1 : 8'd0;
    else if (er && m_cnt != 8'd255) m_cnt = m_cnt + 8'd1;
    if (!en) m_fault = 1'b0;
    else if (er) m_fault = 1'b1;
    else if (en && v && m_ref_ok) m_fault = 1'b0;
    if (!en) m_ref_ok = 1'b0;
    else if (v) begin m_ref_ok = 1'b1; m_ref = c; end
    e.err = er; e.fault = m_fault; e.cnt = m_cnt; e.req = req;
    queue_q.push_back(e);
  endtask

  task automatic idle(input string req);
    step(en_i, 1'b0, cnt_i, 1'b0, req);
  endtask

  // monitor: compare after each edge
  always @(posedge clk_i) begin
    #1;
    if (queue_q.size() > 0) begin
      exp_t e;
      e = queue_q.pop_front();
      n_run++;
      if (err_o !== e.err || fault_o !== e.fault || err_cnt_o !== e.cnt) begin
        n_fail++;
        $display("FAIL %s: err/fault/cnt actual %0b/%0b/%0d expected %0b/%0b/%0d",
                 e.req, err_o, fault_o, err_cnt_o, e.err, e.fault, e.cnt);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_run++;
    if (err_o !== 1'b0 || fault_o !== 1'b0 || err_cnt_o !== 8'd0) begin
      n_fail++;
      $display("FAIL R1: actual %0b/%0b/%0d expected 0/0/0", err_o, fault_o, err_cnt_o);
    end
    rst_ni = 1'b1;

    // R7: first value only sets reference
    step(1, 1, 8'd40, 0, "R7 baseline");
    // R2: correct increments
    step(1, 1, 8'd41, 0, "R2 step");
    step(1, 1, 8'd42, 0, "R2 step");
    idle("R2 idle");
    // R3: wrap
    step(1, 1, 8'd254, 0, "R4 jump");
    step(1, 1, 8'd255, 0, "R11 recover");
    step(1, 1, 8'd0, 0, "R3 wrap");
    step(1, 1, 8'd1, 0, "R3 after wrap");
    // R5: repeat
    step(1, 1, 8'd1, 0, "R5 repeat");
    idle("R11 sticky idle");
    idle("R11 sticky idle");
    step(1, 1, 8'd2, 0, "R11 clear on good");
    // R6: single jump then good steps
    step(1, 1, 8'd9, 0, "R6 jump");
    step(1, 1, 8'd10, 0, "R6 resume");
    step(1, 1, 8'd11, 0, "R6 resume");
    step(1, 1, 8'd12, 0, "R6 resume");
    // R8: disabled ignores samples
    step(1, 1, 8'd50, 0, "R4 set fault");
    step(0, 1, 8'd99, 0, "R8 disabled");
    step(0, 1, 8'd7, 0, "R8 disabled");
    idle("R8 disabled idle");
    // R7: first after enable
    step(1, 1, 8'd200, 0, "R7 after enable");
    step(1, 1, 8'd201, 0, "R2 step");
    // R10: clear, then clear with coincident error
    step(1, 0, 8'd0, 1, "R10 clear");
    step(1, 1, 8'd5, 1, "R10 clear with err");
    step(1, 1, 8'd6, 0, "R2 step");
    // R9: saturation by repeated values
    for (int i = 0; i < 260; i++) step(1, 1, 8'd6, 0, "R9 saturate");
    idle("R9 hold");
    step(1, 0, 8'd0, 1, "R10 clear from max");
    idle("R10 idle");
    idle("R10 idle");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule